// File: doc/BRIEF.md
# Test Wrapper Input Boundary Cell

This block sits between one network link and the matching input port of a router, as one cell of the test wrapper around that router. Flits travel on several prioritised virtual channels. Each channel has its own send strobe and its own accept strobe, and the flit data bus is shared by all channels. A sender may raise `send[i]` in a cycle only if the receiver raised `accept[i]` in the cycle before. Because of this, a flit that is sent is always taken.

A 3-bit mode code from the local test controller selects where flits come from and where they go. In the transparent modes, network flits reach the router, or a bypass link, in the same cycle. In the staged modes, a flit from the network or from the previous cell of the shift chain is first captured in a one-flit slot per virtual channel. It leaves on the following transfer cycle, either to the next chain cell or to the router. A chain of these cells can shift test vectors into place, load them into the router, or take new vectors from the network.

Top module: `tw_input_cell`

## Requirements
- R1: After reset no output link raises any send bit, and in a staged mode both input accepts of the active source are high because every slot is empty.
- R2: Mode codes 0, 5, 6 and 7 are transparent. Network send, data and virtual channel appear on the router link in the same cycle, and the network accept follows the router accept. The chain-out and bypass links stay idle.
- R3: Mode code 3 (bypass) passes network flits to the bypass link in the same cycle, with the network accept following the bypass accept. The router link stays idle.
- R4: Mode code 1 (shift) captures a chain-in flit. It emits the flit on the chain-out link in the cycle after capture, provided the chain-out accept of that channel was high in the capture cycle.
- R5: Mode code 2 (load) captures a chain-in flit and emits it on the router link under the same timing rule as R4.
- R6: Mode code 4 (update) captures a network flit and emits it on the chain-out link under the same timing rule as R4.
- R7: A staged flit is sent on channel i only in a cycle that follows a cycle in which the destination accept bit i was high. Until then the flit is held, with its data unchanged.
- R8: The input accept bit i of the active source is low while slot i holds a flit or is capturing one. Accepts of input links that the current mode does not use are low.
- R9: When staged flits on several channels are eligible in the same cycle, only one is sent, and the lowest index (channel 0, highest priority) goes first.
- R10: A flit leaves on the same virtual channel it arrived on (send bit position i in, bit position i out), with its data unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode_i | input | 3 | Mode code: 0 transparent, 1 shift, 2 load, 3 bypass, 4 update, others transparent |
| net_send_i | input | NUM_VC | Network link send, one bit per channel |
| net_data_i | input | FLIT_W | Network link flit data |
| net_accept_o | output | NUM_VC | Network link accept |
| chn_send_i | input | NUM_VC | Chain-in send from previous cell |
| chn_data_i | input | FLIT_W | Chain-in flit data |
| chn_accept_o | output | NUM_VC | Chain-in accept |
| rtr_send_o | output | NUM_VC | Router link send |
| rtr_data_o | output | FLIT_W | Router link flit data |
| rtr_accept_i | input | NUM_VC | Router link accept |
| nxt_send_o | output | NUM_VC | Chain-out send to next cell |
| nxt_data_o | output | FLIT_W | Chain-out flit data |
| nxt_accept_i | input | NUM_VC | Chain-out accept |
| byp_send_o | output | NUM_VC | Bypass link send |
| byp_data_o | output | FLIT_W | Bypass link flit data |
| byp_accept_i | input | NUM_VC | Bypass link accept |

## Verification
Transparent and bypass results are combinational, so the bench drives them just after a falling edge and checks them in the same cycle. A staged flit is due exactly one rising edge after it is captured, when the destination accept was high in the capture cycle. Otherwise it is due one edge after the first cycle in which that accept is high. The bench checks the idle output in the capture cycle and the flit in the due cycle, and checks that the output is idle again afterwards. The priority and hold scenarios keep the destination accept low for several cycles, and they check each held cycle before the release.

// File: rtl/tw_input_cell.sv
module tw_input_cell #(
  parameter int NUM_VC = 2,
  parameter int FLIT_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [2:0]        mode_i,
  input  logic [NUM_VC-1:0] net_send_i,
  input  logic [FLIT_W-1:0] net_data_i,
  output logic [NUM_VC-1:0] net_accept_o,
  input  logic [NUM_VC-1:0] chn_send_i,
  input  logic [FLIT_W-1:0] chn_data_i,
  output logic [NUM_VC-1:0] chn_accept_o,
  output logic [NUM_VC-1:0] rtr_send_o,
  output logic [FLIT_W-1:0] rtr_data_o,
  input  logic [NUM_VC-1:0] rtr_accept_i,
  output logic [NUM_VC-1:0] nxt_send_o,
  output logic [FLIT_W-1:0] nxt_data_o,
  input  logic [NUM_VC-1:0] nxt_accept_i,
  output logic [NUM_VC-1:0] byp_send_o,
  output logic [FLIT_W-1:0] byp_data_o,
  input  logic [NUM_VC-1:0] byp_accept_i
);

  localparam logic [2:0] M_SHIFT  = 3'd1;
  localparam logic [2:0] M_LOAD   = 3'd2;
  localparam logic [2:0] M_BYPASS = 3'd3;
  localparam logic [2:0] M_UPDATE = 3'd4;

  logic is_shift, is_load, is_byp, is_upd, staged, transp, from_chn;
  assign is_shift = (mode_i == M_SHIFT);
  assign is_load  = (mode_i == M_LOAD);
  assign is_byp   = (mode_i == M_BYPASS);
  assign is_upd   = (mode_i == M_UPDATE);
  assign staged   = is_shift | is_load | is_upd;
  assign transp   = ~(staged | is_byp);
  assign from_chn = is_shift | is_load;

  logic [NUM_VC-1:0] slot_v;
  logic [FLIT_W-1:0] slot_d [NUM_VC];
  logic [NUM_VC-1:0] rtr_acc_q, nxt_acc_q;

  logic [NUM_VC-1:0] src_send, cap, elig, grant;
  logic [FLIT_W-1:0] src_data, out_data;

  assign src_send = staged ? (from_chn ? chn_send_i : net_send_i) : '0;
  assign src_data = from_chn ? chn_data_i : net_data_i;
  assign cap      = src_send & ~slot_v;
  assign elig     = staged ? (slot_v & (is_load ? rtr_acc_q : nxt_acc_q)) : '0;
  assign grant    = elig & (~elig + 1'b1);

  always_comb begin
    out_data = '0;
    for (int i = 0; i < NUM_VC; i++)
      if (grant[i]) out_data = slot_d[i];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      slot_v    <= '0;
      rtr_acc_q <= '0;
      nxt_acc_q <= '0;
    end else begin
      slot_v    <= (slot_v & ~grant) | cap;
      rtr_acc_q <= rtr_accept_i;
      nxt_acc_q <= nxt_accept_i;
    end
  end

  generate
    for (genvar g = 0; g < NUM_VC; g++) begin : g_slot
      always_ff @(posedge clk) begin
        if (!rst_n)      slot_d[g] <= '0;
        else if (cap[g]) slot_d[g] <= src_data;
      end
    end
  endgenerate

  assign rtr_send_o   = transp ? net_send_i : (is_load ? grant : '0);
  assign rtr_data_o   = transp ? net_data_i : out_data;
  assign nxt_send_o   = (is_shift | is_upd) ? grant : '0;
  assign nxt_data_o   = out_data;
  assign byp_send_o   = is_byp ? net_send_i : '0;
  assign byp_data_o   = net_data_i;

  assign net_accept_o = transp ? rtr_accept_i :
                        is_byp ? byp_accept_i :
                        is_upd ? (~slot_v & ~net_send_i) : '0;
  assign chn_accept_o = from_chn ? (~slot_v & ~chn_send_i) : '0;

  generate
    for (genvar a = 0; a < NUM_VC; a++) begin : g_chk
      AST_RTR_CREDIT: assert property (@(posedge clk) disable iff (!rst_n)
        rtr_send_o[a] |-> $past(rtr_accept_i[a])); // R7
      AST_NXT_CREDIT: assert property (@(posedge clk) disable iff (!rst_n)
        nxt_send_o[a] |-> $past(nxt_accept_i[a])); // R7
      AST_BYP_CREDIT: assert property (@(posedge clk) disable iff (!rst_n)
        byp_send_o[a] |-> $past(byp_accept_i[a])); // R3
      AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        (staged && src_send[a]) |-> !slot_v[a]); // R8
      AST_HOLD_DATA: assert property (@(posedge clk) disable iff (!rst_n)
        (slot_v[a] && !grant[a]) |=> (slot_v[a] && $stable(slot_d[a]))); // R7
    end
  endgenerate

  AST_ONE_NXT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(nxt_send_o)); // R9
  AST_ONE_RTR: assert property (@(posedge clk) disable iff (!rst_n)
    staged |-> $onehot0(rtr_send_o)); // R9

endmodule

// File: tb/tw_input_cell_tb.sv
`timescale 1ns/1ps
module tw_input_cell_tb;
  localparam int NV = 2;
  localparam int FW = 32;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [2:0]    mode = 3'd0;
  logic [NV-1:0] net_send = '0, chn_send = '0;
  logic [FW-1:0] net_data = '0, chn_data = '0;
  logic [NV-1:0] rtr_acc = '1, nxt_acc = '1, byp_acc = '1;
  logic [NV-1:0] net_acc, chn_acc, rtr_send, nxt_send, byp_send;
  logic [FW-1:0] rtr_data, nxt_data, byp_data;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  tw_input_cell #(.NUM_VC(NV), .FLIT_W(FW)) u_dut (
    .clk(clk), .rst_n(rst_n), .mode_i(mode),
    .net_send_i(net_send), .net_data_i(net_data), .net_accept_o(net_acc),
    .chn_send_i(chn_send), .chn_data_i(chn_data), .chn_accept_o(chn_acc),
    .rtr_send_o(rtr_send), .rtr_data_o(rtr_data), .rtr_accept_i(rtr_acc),
    .nxt_send_o(nxt_send), .nxt_data_o(nxt_data), .nxt_accept_i(nxt_acc),
    .byp_send_o(byp_send), .byp_data_o(byp_data), .byp_accept_i(byp_acc)
  );

  task automatic check(string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  task automatic idle_all();
    net_send = '0; chn_send = '0;
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    repeat (3) step();
    rst_n = 1'b1;
    mode = 3'd1;
    step(); #1;
    check("R1 rtr_send", rtr_send, 0);
    check("R1 nxt_send", nxt_send, 0);
    check("R1 byp_send", byp_send, 0);
    check("R1 chn_acc", chn_acc, 2'b11);
  endtask

  task automatic t_normal(logic [2:0] code);
    mode = code; idle_all();
    step();
    net_send = 2'b10; net_data = 32'hA5A5_0000 | code; #1;
    check("R2 rtr_send", rtr_send, 2'b10);
    check("R2 rtr_data", rtr_data, 32'hA5A5_0000 | code);
    check("R2 nxt/byp idle", {nxt_send, byp_send}, 0);
    step(); net_send = '0; rtr_acc = 2'b01; #1;
    check("R2 net_acc follows rtr", net_acc, 2'b01);
    step(); rtr_acc = '1; step();
  endtask

  task automatic t_bypass();
    mode = 3'd3; idle_all();
    step();
    net_send = 2'b01; net_data = 32'h0B0B_1234; #1;
    check("R3 byp_send", byp_send, 2'b01);
    check("R3 byp_data", byp_data, 32'h0B0B_1234);
    check("R3 rtr idle", rtr_send, 0);
    step(); net_send = '0; byp_acc = 2'b10; #1;
    check("R3 net_acc follows byp", net_acc, 2'b10);
    check("R8 chn_acc unused", chn_acc, 0);
    step(); byp_acc = '1; step();
  endtask

  task automatic t_staged(logic [2:0] code, bit src_net, bit to_rtr, int vc,
                          logic [FW-1:0] d, string req);
    mode = code; idle_all();
    step(); step();
    if (src_net) begin net_send = NV'(1) << vc; net_data = d; end
    else begin chn_send = NV'(1) << vc; chn_data = d; end
    #1;
    check({req, " idle at capture"}, {rtr_send, nxt_send}, 0);
    check("R8 accept low at capture", (src_net ? net_acc[vc] : chn_acc[vc]), 0);
    step(); idle_all(); #1;
    if (to_rtr) begin
      check({req, " rtr_send"}, rtr_send, NV'(1) << vc);
      check({req, " R10 rtr_data"}, rtr_data, d);
      check({req, " nxt idle"}, nxt_send, 0);
    end else begin
      check({req, " nxt_send"}, nxt_send, NV'(1) << vc);
      check({req, " R10 nxt_data"}, nxt_data, d);
      check({req, " rtr idle"}, rtr_send, 0);
    end
    step(); #1;
    check({req, " single emission"}, {rtr_send, nxt_send}, 0);
  endtask

  task automatic t_priority();
    mode = 3'd1; idle_all(); nxt_acc = '0;
    step(); step();
    chn_send = 2'b10; chn_data = 32'h1111_0001;
    step(); chn_send = 2'b01; chn_data = 32'h0000_0000;
    step(); chn_send = '0; nxt_acc = '1; #1;
    check("R7 held while accept low", nxt_send, 0);
    check("R8 chn_acc while held", chn_acc, 0);
    step(); #1;
    check("R9 vc0 first", nxt_send, 2'b01);
    check("R9 vc0 data", nxt_data, 32'h0000_0000);
    step(); #1;
    check("R9 vc1 second", nxt_send, 2'b10);
    check("R10 vc1 data", nxt_data, 32'h1111_0001);
    step(); #1;
    check("R8 chn_acc freed", chn_acc, 2'b11);
  endtask

  task automatic t_hold();
    mode = 3'd2; idle_all(); rtr_acc = '0;
    step(); step();
    chn_send = 2'b10; chn_data = 32'hDEAD_BEEF;
    step(); chn_send = '0; #1;
    check("R7 load held", rtr_send, 0);
    step(); rtr_acc = '1; #1;
    check("R7 still held", rtr_send, 0);
    check("R8 chn_acc vc1 low", chn_acc[1], 0);
    step(); #1;
    check("R5 released rtr_send", rtr_send, 2'b10);
    check("R10 released data", rtr_data, 32'hDEAD_BEEF);
    step(); #1;
    check("R5 single emission", rtr_send, 0);
  endtask

  initial begin
    #(4 * 5000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual running expected finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_normal(3'd0);
    t_normal(3'd6);
    t_bypass();
    t_staged(3'd1, 1'b0, 1'b0, 0, 32'h5151_0000, "R4");
    t_staged(3'd2, 1'b0, 1'b1, 1, 32'h2222_3333, "R5");
    t_staged(3'd4, 1'b1, 1'b0, 1, 32'h4444_5555, "R6");
    t_priority();
    t_hold();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule